// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the instruction fetch address for a small microcontroller core. A 13-bit program counter covers a program space of 8K words, each 14 bits wide. The space is split into four 2K-word pages, and the current page is driven out as a separate field. The counter advances once in each enabled instruction cycle. It can be redirected by a jump or a call, restored by a return-class instruction, or forced to the fixed interrupt vector.

Return addresses go into a private eight-entry circular stack that software cannot read. Both calls and interrupt entry push onto it. Every return flavour, including a return that carries a literal and a return from interrupt, pops one entry. The decoder folds them all into a single pop request. A depth count from 0 to 8 is brought out so that a bench can follow the stack.

The active-low reset is asynchronous on assertion and released through a two-stage synchronizer. The block only acts in cycles where the instruction-cycle enable is high.

Top module: `pc_retstack`

## Requirements
- R1: While reset is asserted, and after reset is released, `fetch_addr` is 0000h and `depth` is 0.
- R2: In an enabled cycle with no control request, `fetch_addr` increases by one on the next edge, and 1FFFh is followed by 0000h.
- R3: An enabled jump request loads `fetch_addr` from `target` on the next edge, and `depth` does not change.
- R4: An enabled call request loads `fetch_addr` from `target` and pushes the value `fetch_addr + 1`. Below a depth of 8, `depth` increases by one.
- R5: An enabled return request loads `fetch_addr` with the most recently pushed entry. Above a depth of 0, `depth` decreases by one.
- R6: An enabled interrupt request loads `fetch_addr` with 0004h and pushes the current `fetch_addr`. It overrides jump, call and return requests in the same cycle.
- R7: When jump, call and return requests arrive together without an interrupt, call wins over jump and jump wins over return. The losing requests have no effect on the stack or on `depth`.
- R8: While `cyc_en` is low, `fetch_addr` and `depth` hold their values, whatever the request inputs do.
- R9: A ninth push with no pop in between overwrites the oldest entry, and `depth` stays at 8. Eight following returns give back the eight newest addresses, newest first.
- R10: A return at depth 0 is not flagged. `depth` stays 0, the stack pointer wraps backwards, and `fetch_addr` loads the entry held in the slot below the wrapped pointer.
- R11: `page` always equals bits 12:11 of `fetch_addr`. Page 0 is 0000h–07FFh, page 1 is 0800h–0FFFh, page 2 is 1000h–17FFh and page 3 is 1800h–1FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_en | input | 1 | Instruction-cycle enable |
| irq_take | input | 1 | Accept an interrupt this cycle |
| jmp_req | input | 1 | Jump to `target` |
| call_req | input | 1 | Call `target` and push the return address |
| ret_req | input | 1 | Any return-class instruction: pop into the counter |
| target | input | 13 | Jump or call destination |
| fetch_addr | output | 13 | Current program counter |
| page | output | 2 | Current page number |
| depth | output | 4 | Number of valid stack entries, 0 to 8 |

## Verification
The bench targets the page crossing at 07FFh→0800h and the wrap from 1FFFh to 0000h. A design that carried into a 14th bit, or that reported a stale page, fails the check at those points.

Interrupts that coincide with jumps, and mixed jump, call and return requests, show whether the priority order is right. Getting it wrong leads to a wrong vector or a stray push or pop.

The bench pushes nine entries and then pops nine times. The last pop lands on an empty stack. A design that saturated the pointer, or that let `depth` go past 8 or below 0, returns the wrong address sequence.

A mid-run reset and a disabled cycle with a pending jump complete the run.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_INC  = 3'd1,
    SEL_JMP  = 3'd2,
    SEL_CALL = 3'd3,
    SEL_RET  = 3'd4,
    SEL_IRQ  = 3'd5
  } pc_sel_e;
endpackage

// File: rtl/pc_arbiter.sv
module pc_arbiter
  import pc_pkg::*;
(
  input  logic    cyc_en,
  input  logic    irq_take,
  input  logic    jmp_req,
  input  logic    call_req,
  input  logic    ret_req,
  output pc_sel_e sel,
  output logic    push,
  output logic    pop
);
  // priority: interrupt > call > jump > return > increment (R6, R7)
  always_comb begin
    if (!cyc_en)       sel = SEL_HOLD;
    else if (irq_take) sel = SEL_IRQ;
    else if (call_req) sel = SEL_CALL;
    else if (jmp_req)  sel = SEL_JMP;
    else if (ret_req)  sel = SEL_RET;
    else               sel = SEL_INC;
  end

  assign push = (sel == SEL_IRQ) || (sel == SEL_CALL);
  assign pop  = (sel == SEL_RET);
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int W = 13,
  parameter int N = 8,
  localparam int SP_W  = $clog2(N),
  localparam int DEP_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     push_data,
  output logic [W-1:0]     top_data,
  output logic [DEP_W-1:0] depth
);
  logic [W-1:0]     slot [N];
  logic [SP_W-1:0]  sp_q, sp_d;
  logic [DEP_W-1:0] dep_q, dep_d;

  // next state: pointer wraps both ways, depth saturates (R9, R10)
  always_comb begin
    sp_d  = sp_q;
    dep_d = dep_q;
    if (push) begin
      sp_d  = sp_q + SP_W'(1);
      dep_d = (dep_q == DEP_W'(N)) ? dep_q : dep_q + DEP_W'(1);
    end else if (pop) begin
      sp_d  = sp_q - SP_W'(1);
      dep_d = (dep_q == '0) ? dep_q : dep_q - DEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      dep_q <= '0;
    end else if (push || pop) begin
      sp_q  <= sp_d;
      dep_q <= dep_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (sp_q == SP_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) slot[i] <= push_data;
    end
  end

  assign top_data = slot[sp_q - SP_W'(1)];
  assign depth    = dep_q;
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int          W       = 13,
  parameter logic [W-1:0] IRQ_VEC = 4
) (
  input  pc_sel_e      sel,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] target,
  input  logic [W-1:0] pop_data,
  output logic [W-1:0] pc_d,
  output logic [W-1:0] push_data
);
  logic [W-1:0] pc_inc;
  assign pc_inc = pc_q + W'(1);

  always_comb begin
    unique case (sel)
      SEL_INC:  pc_d = pc_inc;
      SEL_JMP:  pc_d = target;
      SEL_CALL: pc_d = target;
      SEL_RET:  pc_d = pop_data;
      SEL_IRQ:  pc_d = IRQ_VEC;
      default:  pc_d = pc_q;
    endcase
  end

  // call saves the next instruction, interrupt saves the one it pre-empts
  assign push_data = (sel == SEL_IRQ) ? pc_q : pc_inc;
endmodule

// File: rtl/pc_retstack.sv
module pc_retstack
  import pc_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int STK_N  = 8,
  parameter int PAGE_W = 2,
  parameter int IRQ_AT = 4,
  localparam int DEP_W = $clog2(STK_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              irq_take,
  input  logic              jmp_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   fetch_addr,
  output logic [PAGE_W-1:0] page,
  output logic [DEP_W-1:0]  depth
);
  logic [1:0]      rst_sync;
  logic            rst_ok;
  pc_sel_e         sel;
  logic            push, pop;
  logic [PC_W-1:0] pc_q, pc_d, push_data, pop_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  pc_arbiter u_arb (
    .cyc_en  (cyc_en),
    .irq_take(irq_take),
    .jmp_req (jmp_req),
    .call_req(call_req),
    .ret_req (ret_req),
    .sel     (sel),
    .push    (push),
    .pop     (pop)
  );

  pc_next #(.W(PC_W), .IRQ_VEC(PC_W'(IRQ_AT))) u_next (
    .sel      (sel),
    .pc_q     (pc_q),
    .target   (target),
    .pop_data (pop_data),
    .pc_d     (pc_d),
    .push_data(push_data)
  );

  pc_stack #(.W(PC_W), .N(STK_N)) u_stk (
    .clk      (clk),
    .rst_n    (rst_ok),
    .push     (push),
    .pop      (pop),
    .push_data(push_data),
    .top_data (pop_data),
    .depth    (depth)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     pc_q <= '0;
    else if (cyc_en) pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;
  assign page       = pc_q[PC_W-1 -: PAGE_W];
endmodule

// File: rtl/pc_retstack_chk.sv
module pc_retstack_chk #(
  parameter int PC_W  = 13,
  parameter int STK_N = 8,
  parameter int DEP_W = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             cyc_en,
  input logic             irq_take,
  input logic             jmp_req,
  input logic             call_req,
  input logic             ret_req,
  input logic [PC_W-1:0]  target,
  input logic [PC_W-1:0]  fetch_addr,
  input logic [DEP_W-1:0] depth
);
  logic quiet;
  assign quiet = cyc_en && !irq_take && !jmp_req && !call_req && !ret_req;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !cyc_en |=> $stable(fetch_addr) && $stable(depth));

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    quiet |=> fetch_addr == $past(fetch_addr) + PC_W'(1));

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    cyc_en && !irq_take && jmp_req && !call_req |=> fetch_addr == $past(target) && $stable(depth));

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    cyc_en && irq_take |=> fetch_addr == PC_W'(4));

  p_call_depth_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    cyc_en && !irq_take && call_req && depth < DEP_W'(STK_N) |=> depth == $past(depth) + DEP_W'(1));

  p_pop_depth_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    cyc_en && !irq_take && !call_req && !jmp_req && ret_req && depth != '0
      |=> depth == $past(depth) - DEP_W'(1));

  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    depth <= DEP_W'(STK_N));
endmodule

bind pc_retstack pc_retstack_chk #(.PC_W(PC_W), .STK_N(STK_N), .DEP_W(DEP_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .cyc_en    (cyc_en),
  .irq_take  (irq_take),
  .jmp_req   (jmp_req),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .target    (target),
  .fetch_addr(fetch_addr),
  .depth     (depth)
);

// File: tb/pc_retstack_bench.sv
module pc_retstack_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_en, irq_take, jmp_req, call_req, ret_req;
  logic [12:0] target;
  logic [12:0] fetch_addr;
  logic [1:0]  page;
  logic [3:0]  depth;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  pc_retstack u_pc_retstack (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_take(irq_take),
    .jmp_req(jmp_req), .call_req(call_req), .ret_req(ret_req),
    .target(target), .fetch_addr(fetch_addr), .page(page), .depth(depth)
  );

  // {irq,jmp,call,ret}, target, expected pc, expected depth
  localparam int NV = 13;
  localparam logic [33:0] VEC [NV] = '{
    {4'b0000, 13'h0000, 13'h0001, 4'd0}, // R2 increment
    {4'b0100, 13'h07FF, 13'h07FF, 4'd0}, // R3 jump to end of page 0
    {4'b0000, 13'h0000, 13'h0800, 4'd0}, // R2 R11 page crossing
    {4'b0010, 13'h1234, 13'h1234, 4'd1}, // R4 call pushes 0801
    {4'b0000, 13'h0000, 13'h1235, 4'd1}, // R2
    {4'b1100, 13'h0AAA, 13'h0004, 4'd2}, // R6 irq beats jump, pushes 1235
    {4'b0001, 13'h0000, 13'h1235, 4'd1}, // R5
    {4'b0001, 13'h0000, 13'h0801, 4'd0}, // R5
    {4'b0100, 13'h1FFF, 13'h1FFF, 4'd0}, // R3
    {4'b0000, 13'h0000, 13'h0000, 4'd0}, // R2 wrap
    {4'b0111, 13'h0100, 13'h0100, 4'd1}, // R7 call wins, pushes 0001
    {4'b0101, 13'h0ABC, 13'h0ABC, 4'd1}, // R7 jump beats return
    {4'b0001, 13'h0000, 13'h0001, 4'd0}  // R5 R7 return gives 0001
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one posedge between)
  task automatic step(input logic [3:0] ctl, input logic [12:0] tgt);
    {irq_take, jmp_req, call_req, ret_req} = ctl;
    target = tgt;
    cyc_en = 1'b1;
    @(negedge clk);
    {irq_take, jmp_req, call_req, ret_req} = 4'b0000;
    cyc_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc_en = 1'b0;
    {irq_take, jmp_req, call_req, ret_req} = 4'b0000;
    target = '0;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", int'(fetch_addr), 0);
    check("R1 depth in reset", int'(depth), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc after reset", int'(fetch_addr), 0);
    check("R1 depth after reset", int'(depth), 0);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [12:0] pushed [9];
    logic [12:0] held;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33:30], VEC[i][29:17]);
      check($sformatf("R2-7 vector %0d pc", i), int'(fetch_addr), int'(VEC[i][16:4]));
      check($sformatf("R4/R5 vector %0d depth", i), int'(depth), int'(VEC[i][3:0]));
      check($sformatf("R11 vector %0d page", i), int'(page), int'(VEC[i][16:15]));
    end

    // R8: disabled cycle with a pending jump and call changes nothing
    held = fetch_addr;
    jmp_req = 1'b1; call_req = 1'b1; target = 13'h1555; cyc_en = 1'b0;
    @(negedge clk);
    check("R8 pc held", int'(fetch_addr), int'(held));
    check("R8 depth held", int'(depth), 0);
    jmp_req = 1'b0; call_req = 1'b0;

    // R9: nine calls, oldest overwritten, depth stays at 8
    for (int k = 0; k < 9; k++) begin
      pushed[k] = fetch_addr + 13'd1;
      step(4'b0010, 13'h0200 + 13'(k * 16));
      check("R4 call target", int'(fetch_addr), int'(13'h0200 + 13'(k * 16)));
    end
    check("R9 depth capped", int'(depth), 8);
    for (int k = 8; k >= 1; k--) begin
      step(4'b0001, 13'h0000);
      check($sformatf("R9 pop %0d", k), int'(fetch_addr), int'(pushed[k]));
    end
    check("R9 depth drained", int'(depth), 0);

    // R10: pop at depth 0 wraps onto the slot holding the ninth push
    step(4'b0001, 13'h0000);
    check("R10 underflow pc", int'(fetch_addr), int'(pushed[8]));
    check("R10 underflow depth", int'(depth), 0);
    check("R11 underflow page", int'(page), int'(pushed[8][12:11]));

    // R6: interrupt pushes the pre-empted address, return resumes it
    step(4'b0000, 13'h0000);
    held = fetch_addr;
    step(4'b1011, 13'h1F00);
    check("R6 vector", int'(fetch_addr), 4);
    check("R6 depth", int'(depth), 1);
    step(4'b0001, 13'h0000);
    check("R6 resume", int'(fetch_addr), int'(held));

    // R1: reset in mid-run
    step(4'b0010, 13'h1ABC);
    check("R11 page 3", int'(page), 3);
    do_reset();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule